// File: doc/BRIEF.md
# Streaming Histogram Binner with Forwarding

This block builds a histogram from a stream of (index, weight) pairs. Each cycle in which the input strobe is high, it takes one pair and adds the weight to the bin that the index selects. The bins sit in an internal memory with a registered read, and each is updated by a read, an add and a write-back. Because that loop spans several cycles, a read can return a bin whose new sum has not been written yet. A forwarding stage detects this and supplies the newest pending sum, so any run of repeated indices is accepted at one pair per clock with no stall.

A second access path lets a host clear bins (by writing zero), preload them, or read the finished counts. This path is honoured only while the stream is idle and the pipeline is empty, which the block reports on its ready output. Sums wrap modulo 2^32.

Top module: `hist_binner`

## Requirements
- R1: On each clock edge where `in_valid` is high, the pair on `in_index`/`in_value` is consumed with no stall. Only `in_index[9:0]` selects one of the 1024 bins; bits 31..10 have no effect.
- R2: After the pipeline drains, each bin holds its previous contents plus the sum of every accepted weight whose index selected it.
- R3: An edge where `in_valid` is low adds nothing to any bin.
- R4: A pair that reuses the bin of either of the two pairs accepted just before it (back to back, or with one pair between) still gets the up-to-date bin value. No update is lost.
- R5: When both earlier pending updates target the same bin as a new pair, the newer of the two is the one that is added to.
- R6: `host_ready` is high exactly when `in_valid` is low and no accepted pair remains in the pipeline, which is from the fourth edge after the last accepted pair. While `host_ready` is low, host requests change nothing.
- R7: While `host_ready` is high and `host_en` is high, `host_we`=1 writes `host_wdata` into bin `host_addr` (zero clears it). `host_we`=0 reads the bin, and the data is on `host_rdata` after the next edge.
- R8: Bin sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| in_valid | input | 1 | Qualifies the stream pair |
| in_index | input | 32 | Bin index; the low 10 bits are used |
| in_value | input | 32 | Weight added to the bin |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write bin, 0 = read bin |
| host_addr | input | 10 | Bin addressed by the host |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the request |
| host_ready | output | 1 | Host access is honoured |

## Verification
The hardest state to reach is one where both pending updates and the new pair all hit the same bin while the memory still holds an older value, because only then does the priority between the two forwarding sources matter. The stimulus reaches it with runs of one repeated index and with alternating patterns (A,B,A / A,A,B,A). These runs use index values whose upper bits differ while their low bits match, and they are interleaved with idle gaps of one and two cycles that move a match from the newer slot to the older one. The bench also issues host writes while the stream is active and later reads those bins back to confirm they were ignored.

// File: rtl/hist_pkg.sv
package hist_pkg;
    parameter int BIN_AW = 10;
    parameter int DATA_W = 32;
    parameter int IDX_W  = 32;

    typedef struct packed {
        logic              vld;
        logic [BIN_AW-1:0] bin;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t rd;   // read issued, memory data arriving
        slot_t wr;   // sum computed, written this cycle
        slot_t dn;   // written last cycle, still forwardable
    } pipe_t;
endpackage

// File: rtl/hist_bin_mem.sv
module hist_bin_mem #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata_q <= cells[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/hist_fwd.sv
module hist_fwd #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic [AW-1:0] req_bin,
    input  logic [DW-1:0] mem_data,
    input  logic          young_vld,
    input  logic [AW-1:0] young_bin,
    input  logic [DW-1:0] young_sum,
    input  logic          old_vld,
    input  logic [AW-1:0] old_bin,
    input  logic [DW-1:0] old_sum,
    output logic [DW-1:0] base,
    output logic          hit
);
    logic hit_young;
    logic hit_old;

    always_comb begin
        hit_young = young_vld && (young_bin == req_bin);
        hit_old   = old_vld && (old_bin == req_bin);
        hit       = hit_young || hit_old;
        if (hit_young) begin
            base = young_sum;
        end else if (hit_old) begin
            base = old_sum;
        end else begin
            base = mem_data;
        end
    end
endmodule

// File: rtl/hist_binner.sv
module hist_binner
    import hist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [DATA_W-1:0] in_value,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [BIN_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready
);
    pipe_t pipe_d, pipe_q;

    logic [BIN_AW-1:0] in_bin;
    logic              unused_idx_hi;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] fwd_base;
    logic              fwd_hit;
    logic [DATA_W-1:0] rd_sum;
    logic              host_act;
    logic              mem_we;
    logic [BIN_AW-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [BIN_AW-1:0] mem_raddr;

    assign in_bin        = in_index[BIN_AW-1:0];
    assign unused_idx_hi = ^in_index[IDX_W-1:BIN_AW];

    hist_fwd #(.AW(BIN_AW), .DW(DATA_W)) u_fwd (
        .req_bin   (pipe_q.rd.bin),
        .mem_data  (mem_rdata),
        .young_vld (pipe_q.wr.vld),
        .young_bin (pipe_q.wr.bin),
        .young_sum (pipe_q.wr.data),
        .old_vld   (pipe_q.dn.vld),
        .old_bin   (pipe_q.dn.bin),
        .old_sum   (pipe_q.dn.data),
        .base      (fwd_base),
        .hit       (fwd_hit)
    );

    always_comb begin
        host_ready = !in_valid && !pipe_q.rd.vld && !pipe_q.wr.vld && !pipe_q.dn.vld;
        host_act   = host_ready && host_en;
        rd_sum     = fwd_base + pipe_q.rd.data;

        pipe_d.rd.vld  = in_valid;
        pipe_d.rd.bin  = in_bin;
        pipe_d.rd.data = in_value;
        pipe_d.wr.vld  = pipe_q.rd.vld;
        pipe_d.wr.bin  = pipe_q.rd.bin;
        pipe_d.wr.data = rd_sum;
        pipe_d.dn      = pipe_q.wr;

        if (pipe_q.wr.vld) begin
            mem_we    = 1'b1;
            mem_waddr = pipe_q.wr.bin;
            mem_wdata = pipe_q.wr.data;
        end else begin
            mem_we    = host_act && host_we;
            mem_waddr = host_addr;
            mem_wdata = host_wdata;
        end
        mem_raddr = host_act ? host_addr : in_bin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    hist_bin_mem #(.AW(BIN_AW), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign host_rdata = mem_rdata;
endmodule

// File: rtl/hist_binner_chk.sv
module hist_binner_chk
    import hist_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [BIN_AW-1:0] in_bin,
    input logic [DATA_W-1:0] in_value,
    input logic              host_en,
    input logic              host_we,
    input logic              host_ready,
    input pipe_t             pipe_q,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] rd_sum,
    input logic              mem_we
);
    logic m_wr, m_dn;
    assign m_wr = pipe_q.wr.vld && (pipe_q.wr.bin == pipe_q.rd.bin);
    assign m_dn = pipe_q.dn.vld && (pipe_q.dn.bin == pipe_q.rd.bin);

    AST_CAPTURE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (pipe_q.rd.vld && pipe_q.rd.bin == $past(in_bin) && pipe_q.rd.data == $past(in_value))); // R1
    AST_SUM_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.rd.vld && !m_wr && !m_dn) |-> (rd_sum == mem_rdata + pipe_q.rd.data)); // R2
    AST_COMMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.rd.vld |=> (pipe_q.wr.vld && pipe_q.wr.data == $past(rd_sum))); // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_q.wr.vld && !(host_ready && host_en && host_we)) |-> !mem_we); // R3
    AST_FWD_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.rd.vld && m_dn && !m_wr) |-> (rd_sum == pipe_q.dn.data + pipe_q.rd.data)); // R4
    AST_FWD_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.rd.vld && m_wr) |-> (rd_sum == pipe_q.wr.data + pipe_q.rd.data)); // R5
    AST_HOST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (!in_valid && !pipe_q.rd.vld && !pipe_q.wr.vld && !pipe_q.dn.vld)); // R6
endmodule

bind hist_binner hist_binner_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_bin     (in_bin),
    .in_value   (in_value),
    .host_en    (host_en),
    .host_we    (host_we),
    .host_ready (host_ready),
    .pipe_q     (pipe_q),
    .mem_rdata  (mem_rdata),
    .rd_sum     (rd_sum),
    .mem_we     (mem_we)
);

// File: tb/tb_hist_binner.sv
module tb_hist_binner;
    localparam int NB = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_index = '0;
    logic [31:0] in_value = '0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;

    int total = 0;
    int bad = 0;
    logic [31:0] model [NB];

    hist_binner dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_index(in_index),
        .in_value(in_value), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one stream pair; optional host write attempt in the same cycle
    task automatic push(input logic [31:0] idx, input logic [31:0] val, input logic poke);
        @(negedge clk);
        in_valid   = 1'b1;
        in_index   = idx;
        in_value   = val;
        host_en    = poke;
        host_we    = poke;
        host_addr  = 10'd3;
        host_wdata = 32'hDEAD_BEEF;
        #1 check("R6 ready low while streaming", {31'd0, host_ready}, 32'd0);
        model[idx[9:0]] = model[idx[9:0]] + val;
    endtask

    task automatic gap(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_index = 32'hFFFF_FFFF;
            in_value = 32'h1234_5678;
            host_en  = 1'b0;
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        host_en  = 1'b0;
        #1 check("R6 not ready, slot1", {31'd0, host_ready}, 32'd0);
        @(negedge clk); check("R6 not ready, slot2", {31'd0, host_ready}, 32'd0);
        @(negedge clk); check("R6 not ready, slot3", {31'd0, host_ready}, 32'd0);
        @(negedge clk); check("R6 ready after drain", {31'd0, host_ready}, 32'd1);
    endtask

    task automatic hwrite(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        model[a] = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        host_en = 1'b0;
    endtask

    task automatic verify(input string req, input int lo, input int hi);
        logic [31:0] d;
        for (int a = lo; a <= hi; a++) begin
            hread(a[9:0], d);
            check(req, d, model[a]);
        end
    endtask

    initial begin
        logic [31:0] d;
        for (int a = 0; a < NB; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        check("R6 ready after reset", {31'd0, host_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 ready out of reset", {31'd0, host_ready}, 32'd1);

        // R7: clear every bin through the host port
        for (int a = 0; a < NB; a++) hwrite(a[9:0], 32'd0);
        hwrite(10'd7, 32'd100);
        hread(10'd7, d);
        check("R7 host write/read", d, 32'd100);
        hwrite(10'd7, 32'd0);
        hread(10'd7, d);
        check("R7 zero clears bin", d, 32'd0);

        // R4/R5: same bin back to back, upper index bits vary (R1)
        for (int k = 0; k < 8; k++) push({k[21:0], 10'd5}, 32'(k + 1), 1'b0);
        drain();
        verify("R4 repeated bin", 5, 5);
        check("R1 pair count via sum", model[5], 32'd36);

        // R4: A,B,A,B and A,A,B,A patterns
        for (int k = 0; k < 6; k++) push((k % 2 == 0) ? 32'd10 : 32'd11, 32'(10 * k + 3), 1'b0);
        push(32'd12, 32'd1, 1'b0); push(32'h8000_000C, 32'd2, 1'b0);
        push(32'd13, 32'd4, 1'b0); push(32'd12, 32'd8, 1'b0);
        drain();
        verify("R4 alternating bins", 10, 13);

        // R3: idle gaps with junk on the inputs shift the match age
        push(32'd20, 32'd1, 1'b0); gap(1); push(32'd20, 32'd2, 1'b0);
        gap(2); push(32'd20, 32'd4, 1'b0); push(32'd20, 32'd8, 1'b0);
        gap(1); push(32'd21, 32'd16, 1'b0); push(32'd20, 32'd32, 1'b0);
        drain();
        verify("R3 gaps add nothing", 20, 21);
        hread(10'h3FF, d);
        check("R3 idle index untouched", d, 32'd0);

        // R6: host writes during streaming are ignored
        for (int k = 0; k < 4; k++) push(32'd30, 32'd5, 1'b1);
        drain();
        verify("R6 ignored host write", 3, 3);
        verify("R2 bin sum", 30, 30);

        // R8: wraparound
        hwrite(10'd40, 32'hFFFF_FFF0);
        push(32'd40, 32'h0000_0008, 1'b0);
        push(32'd40, 32'h0000_0010, 1'b0);
        push(32'd40, 32'hFFFF_FFFF, 1'b0);
        drain();
        verify("R8 wrap modulo 2^32", 40, 40);
        check("R8 wrap value", model[40], 32'h0000_0007);

        // R2/R5: dense sweep over a small bin set, arithmetic pattern
        for (int k = 0; k < 600; k++) push(32'((k * 7 + k / 3) % 5 + 50) | (32'(k) << 12), 32'(k * 13 + 1), 1'b0);
        drain();
        // R2: every bin checked against the model
        verify("R2 full sweep", 0, NB - 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule